// File: doc/BRIEF.md
# Expansion Bus Port Mode Controller

This block owns three 8-bit pad groups and decides what drives them according to the operating mode. In single-chip mode they are general-purpose ports. Two of them are output-only ports loaded from internal registers. The third is a bidirectional port whose per-bit direction comes from its own direction register. In expanded mode the same pads become a non-multiplexed external bus. One group carries the high address byte and another carries the low address byte. The bidirectional group becomes the data bus. No address strobe is produced, because address and data never share pins.

Once the pins belong to the bus, CPU accesses to the four displaced register addresses no longer reach the internal registers. Such an access goes out on the external bus like any other. The block also drives the external read/write pin. In the two non-bus modes that pin is pinned at read, so a later switch into a bus mode cannot start with a spurious write. In the bus modes the pin follows the CPU. The pin and the write data stay valid for a parameterised number of internal clocks after the E clock falls. The E clock itself is generated elsewhere and arrives as an input.

Top module: `ebus_port_ctl`

## Requirements
- R1: `mode_sel` encodes 2'b00 single-chip, 2'b01 normal expanded, 2'b10 bootstrap, 2'b11 test. The bus modes are those with `mode_sel[0]` = 1.
- R2: In a bus mode, `pb_out` equals `cpu_addr[15:8]` and `pf_out` equals `cpu_addr[7:0]` in the same cycle.
- R3: In a non-bus mode, `pb_out` and `pf_out` show the high-port and low-port registers. A write is a cycle with `cpu_valid`=1 and `cpu_rw`=0. A write to 16'h1004 or 16'h1005 updates the high-port or low-port register respectively, at the next clock edge.
- R4: In a non-bus mode, `pc_oe` equals the direction register (address 16'h1007) and `pc_out` equals the data register (address 16'h1003). A read of 16'h1003 returns the register bits where the direction bit is 1 and the `pc_in` bits where it is 0. Reads of the other three register addresses return their contents.
- R5: In a bus mode, writes to 16'h1003, 16'h1004, 16'h1005 and 16'h1007 leave the internal registers unchanged, and every read returns `pc_in`.
- R6: In single-chip and bootstrap modes, `rw_pin` is 1 regardless of `cpu_rw`.
- R7: In a bus mode, outside the hold window, `rw_pin` equals `cpu_rw` (1 = read).
- R8: In a bus mode, outside the hold window, `pc_oe` is all ones with `pc_out` = `cpu_wdata` only while `e_clk`=1, `cpu_valid`=1 and `cpu_rw`=0. Otherwise `pc_oe` is all zeros, in particular during reads.
- R9: In a bus mode, the hold window covers the first HOLD_CYC clock cycles in which `e_clk` is seen low after being high. During that window `rw_pin`, `pc_out` and `pc_oe` keep the values they had at the last clock edge with `e_clk` high.
- R10: After reset all four internal registers are zero, so in single-chip mode `pb_out`, `pf_out` and `pc_oe` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Operating mode |
| cpu_valid | input | 1 | CPU access in this cycle |
| cpu_rw | input | 1 | CPU direction, 1 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| e_clk | input | 1 | Bus E clock |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| pb_out | output | 8 | High-address / output port pad value |
| pf_out | output | 8 | Low-address / output port pad value |
| pc_in | input | 8 | Data / bidirectional port pad input |
| pc_out | output | 8 | Data / bidirectional port pad value |
| pc_oe | output | 8 | Data / bidirectional port pad enables |
| rw_pin | output | 1 | External read/write pin |

## Verification
The hardest case to reach is the hold window. The CPU has already moved to a read, with new data, while the write of the previous E-high phase must still be visible on the pins. The stimulus runs a write with E high for one clock edge. In the very cycle E drops, it flips `cpu_rw`, `cpu_valid` and the data, so only latched state can keep the pins correct. Register isolation in bus mode is shown by loading the registers in single-chip mode first, writing other values while in bus mode, and then returning to single-chip mode to read the pads.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_BOOT     = 2'b10,
        MODE_TEST     = 2'b11
    } op_mode_e;

    // Bus-owning modes are exactly those with bit 0 set (R1)
    function automatic logic is_bus_mode(op_mode_e m);
        return (m == MODE_EXPANDED) || (m == MODE_TEST);
    endfunction
endpackage

// File: rtl/ebus_port_regs.sv
module ebus_port_regs #(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter logic [15:0] ADDR_DATAC = 16'h1003,
    parameter logic [15:0] ADDR_HIGHB = 16'h1004,
    parameter logic [15:0] ADDR_LOWF  = 16'h1005,
    parameter logic [15:0] ADDR_DIRC  = 16'h1007
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode,
    input  logic          cpu_valid,
    input  logic          cpu_rw,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] highb,
    output logic [DW-1:0] lowf,
    output logic [DW-1:0] datac,
    output logic [DW-1:0] dirc
);
    typedef struct packed {
        logic [DW-1:0] highb;
        logic [DW-1:0] lowf;
        logic [DW-1:0] datac;
        logic [DW-1:0] dirc;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_local;

    always_comb begin
        r_d      = r_q;
        wr_local = cpu_valid && !cpu_rw && !bus_mode;
        if (wr_local) begin
            if (cpu_addr == AW'(ADDR_HIGHB)) r_d.highb = cpu_wdata;
            if (cpu_addr == AW'(ADDR_LOWF))  r_d.lowf  = cpu_wdata;
            if (cpu_addr == AW'(ADDR_DATAC)) r_d.datac = cpu_wdata;
            if (cpu_addr == AW'(ADDR_DIRC))  r_d.dirc  = cpu_wdata;
        end
        // read path: external bus in bus modes, local registers otherwise
        rd_data = '0;
        if (bus_mode) begin
            rd_data = pc_in;
        end else if (cpu_addr == AW'(ADDR_DATAC)) begin
            rd_data = (r_q.datac & r_q.dirc) | (pc_in & ~r_q.dirc);
        end else if (cpu_addr == AW'(ADDR_HIGHB)) begin
            rd_data = r_q.highb;
        end else if (cpu_addr == AW'(ADDR_LOWF)) begin
            rd_data = r_q.lowf;
        end else if (cpu_addr == AW'(ADDR_DIRC)) begin
            rd_data = r_q.dirc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign highb = r_q.highb;
    assign lowf  = r_q.lowf;
    assign datac = r_q.datac;
    assign dirc  = r_q.dirc;
endmodule

// File: rtl/ebus_cycle_hold.sv
module ebus_cycle_hold #(
    parameter int DW       = 8,
    parameter int HOLD_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode,
    input  logic          e_clk,
    input  logic          cpu_rw,
    input  logic          wr_drive,
    input  logic [DW-1:0] cpu_wdata,
    output logic          hold_act,
    output logic          hold_rw,
    output logic          hold_drv,
    output logic [DW-1:0] hold_data
);
    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic          e_prev;
        logic          rw;
        logic          drv;
        logic [DW-1:0] data;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d        = h_q;
        h_d.e_prev = e_clk;
        if (e_clk) begin
            // capture the bus phase while E is high
            h_d.rw   = cpu_rw;
            h_d.drv  = wr_drive;
            h_d.data = cpu_wdata;
            h_d.cnt  = '0;
        end else if (h_q.e_prev) begin
            h_d.cnt = CW'(HOLD_CYC - 1);
        end else if (h_q.cnt != '0) begin
            h_d.cnt = h_q.cnt - 1'b1;
        end
        hold_act = bus_mode && !e_clk && (h_q.e_prev || (h_q.cnt != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{e_prev: 1'b0, rw: 1'b1, drv: 1'b0, data: '0, cnt: '0};
        else        h_q <= h_d;
    end

    assign hold_rw   = h_q.rw;
    assign hold_drv  = h_q.drv;
    assign hold_data = h_q.data;
endmodule

// File: rtl/ebus_port_ctl.sv
module ebus_port_ctl
    import ebus_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter int          HOLD_CYC   = 1,
    parameter logic [15:0] ADDR_DATAC = 16'h1003,
    parameter logic [15:0] ADDR_HIGHB = 16'h1004,
    parameter logic [15:0] ADDR_LOWF  = 16'h1005,
    parameter logic [15:0] ADDR_DIRC  = 16'h1007
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          cpu_valid,
    input  logic          cpu_rw,
    input  logic [15:0]   cpu_addr,
    input  logic [7:0]    cpu_wdata,
    input  logic          e_clk,
    output logic [7:0]    cpu_rdata,
    output logic [7:0]    pb_out,
    output logic [7:0]    pf_out,
    input  logic [7:0]    pc_in,
    output logic [7:0]    pc_out,
    output logic [7:0]    pc_oe,
    output logic          rw_pin
);
    localparam int HW = AW / 2;

    logic          bus_mode;
    logic          wr_drive;
    logic [DW-1:0] rb_highb, rb_lowf, rb_datac, rb_dirc;
    logic          hold_act, hold_rw, hold_drv;
    logic [DW-1:0] hold_data;

    assign bus_mode = is_bus_mode(op_mode_e'(mode_sel));
    assign wr_drive = bus_mode && cpu_valid && !cpu_rw && e_clk;

    ebus_port_regs #(
        .AW(AW), .DW(DW),
        .ADDR_DATAC(ADDR_DATAC), .ADDR_HIGHB(ADDR_HIGHB),
        .ADDR_LOWF(ADDR_LOWF), .ADDR_DIRC(ADDR_DIRC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
        .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .pc_in(pc_in), .rd_data(cpu_rdata),
        .highb(rb_highb), .lowf(rb_lowf), .datac(rb_datac), .dirc(rb_dirc)
    );

    ebus_cycle_hold #(.DW(DW), .HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .e_clk(e_clk),
        .cpu_rw(cpu_rw), .wr_drive(wr_drive), .cpu_wdata(cpu_wdata),
        .hold_act(hold_act), .hold_rw(hold_rw), .hold_drv(hold_drv),
        .hold_data(hold_data)
    );

    always_comb begin
        if (bus_mode) begin
            pb_out = cpu_addr[AW-1:HW];
            pf_out = cpu_addr[HW-1:0];
            if (hold_act) begin
                rw_pin = hold_rw;
                pc_out = hold_data;
                pc_oe  = {DW{hold_drv}};
            end else begin
                rw_pin = cpu_rw;
                pc_out = cpu_wdata;
                pc_oe  = {DW{wr_drive}};
            end
        end else begin
            pb_out = rb_highb;
            pf_out = rb_lowf;
            pc_out = rb_datac;
            pc_oe  = rb_dirc;
            rw_pin = 1'b1;
        end
    end
endmodule

// File: rtl/ebus_port_ctl_chk.sv
module ebus_port_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode_sel,
    input logic        cpu_rw,
    input logic [15:0] cpu_addr,
    input logic        e_clk,
    input logic [7:0]  pb_out,
    input logic [7:0]  pf_out,
    input logic [7:0]  pc_oe,
    input logic        rw_pin,
    input logic [7:0]  r_highb,
    input logic [7:0]  r_lowf,
    input logic [7:0]  r_datac,
    input logic [7:0]  r_dirc
);
    logic busm;
    assign busm = mode_sel[0];

    AST_RW_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busm |-> rw_pin); // R6
    AST_ADDR_ON_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        busm |-> (pb_out == cpu_addr[15:8]) && (pf_out == cpu_addr[7:0])); // R2
    AST_RW_TRACKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (busm && e_clk) |-> (rw_pin == cpu_rw)); // R7
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busm && e_clk && cpu_rw) |-> (pc_oe == 8'h00)); // R8
    AST_DIR_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
        !busm |-> (pc_oe == r_dirc)); // R4
    AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busm |=> (r_highb == $past(r_highb)) && (r_lowf == $past(r_lowf))
              && (r_datac == $past(r_datac)) && (r_dirc == $past(r_dirc))); // R5
    AST_RW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busm && $past(busm) && $past(e_clk) && !e_clk) |-> (rw_pin == $past(cpu_rw))); // R9
endmodule

bind ebus_port_ctl ebus_port_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .e_clk(e_clk), .pb_out(pb_out), .pf_out(pf_out),
    .pc_oe(pc_oe), .rw_pin(rw_pin), .r_highb(rb_highb), .r_lowf(rb_lowf),
    .r_datac(rb_datac), .r_dirc(rb_dirc)
);

// File: tb/sim_ebus_port_ctl.sv
`timescale 1ns/1ps
module sim_ebus_port_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        cpu_valid = 1'b0;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        e_clk = 1'b0;
    logic [7:0]  pc_in = 8'h00;
    logic [7:0]  cpu_rdata, pb_out, pf_out, pc_out, pc_oe;
    logic        rw_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ebus_port_ctl u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cpu_valid(cpu_valid),
        .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .e_clk(e_clk), .cpu_rdata(cpu_rdata), .pb_out(pb_out), .pf_out(pf_out),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .rw_pin(rw_pin)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // inputs change right after a falling edge; results read 1 ns later
    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        step();
        cpu_valid = 1'b1; cpu_rw = 1'b0; cpu_addr = a; cpu_wdata = d;
        step();
        cpu_valid = 1'b0; cpu_rw = 1'b1;
    endtask

    task automatic t_reset();
        #1;
        chk("R10", "pb_out", {8'h0, pb_out}, 16'h0);
        chk("R10", "pf_out", {8'h0, pf_out}, 16'h0);
        chk("R10", "pc_oe", {8'h0, pc_oe}, 16'h0);
    endtask

    task automatic t_single_regs();
        mode_sel = 2'b00;
        wr(16'h1004, 8'h3C);
        wr(16'h1005, 8'hC3);
        wr(16'h1007, 8'h0F);
        wr(16'h1003, 8'h35);
        #1;
        chk("R3", "pb_out reg", {8'h0, pb_out}, 16'h003C);
        chk("R3", "pf_out reg", {8'h0, pf_out}, 16'h00C3);
        chk("R4", "pc_oe dir", {8'h0, pc_oe}, 16'h000F);
        chk("R4", "pc_out reg", {8'h0, pc_out}, 16'h0035);
    endtask

    task automatic t_single_reads();
        step();
        pc_in = 8'hA0; cpu_addr = 16'h1003; #1;
        chk("R4", "portc read mix", {8'h0, cpu_rdata}, 16'h00A5);
        cpu_addr = 16'h1007; #1;
        chk("R4", "dir read", {8'h0, cpu_rdata}, 16'h000F);
        cpu_addr = 16'h1004; #1;
        chk("R4", "high read", {8'h0, cpu_rdata}, 16'h003C);
    endtask

    task automatic t_idle_rw();
        foreach (mode_sel[i]) ;
        for (int m = 0; m < 4; m += 2) begin
            step();
            mode_sel = m[1:0]; cpu_valid = 1'b1; cpu_rw = 1'b0; e_clk = 1'b1;
            cpu_addr = 16'h2000; #1;
            chk("R6", $sformatf("rw_pin mode %0d", m), {15'h0, rw_pin}, 16'h1);
        end
        step();
        cpu_valid = 1'b0; cpu_rw = 1'b1; e_clk = 1'b0; mode_sel = 2'b00;
    endtask

    task automatic t_bus_addr();
        step();
        mode_sel = 2'b01; cpu_addr = 16'hBEEF; #1;
        chk("R2", "pb addr hi", {8'h0, pb_out}, 16'h00BE);
        chk("R2", "pf addr lo", {8'h0, pf_out}, 16'h00EF);
        step();
        mode_sel = 2'b11; cpu_addr = 16'h1234; #1;
        chk("R1", "test mode is bus mode", {pb_out, pf_out}, 16'h1234);
    endtask

    task automatic t_isolation();
        step();
        mode_sel = 2'b01;
        e_clk = 1'b1;
        wr(16'h1004, 8'h11);
        wr(16'h1005, 8'h22);
        wr(16'h1007, 8'hFF);
        wr(16'h1003, 8'h44);
        step();
        pc_in = 8'h6B; cpu_addr = 16'h1004; #1;
        chk("R5", "bus read returns pad", {8'h0, cpu_rdata}, 16'h006B);
        step();
        e_clk = 1'b0; step();
        mode_sel = 2'b00; #1;
        chk("R5", "high reg kept", {8'h0, pb_out}, 16'h003C);
        chk("R5", "low reg kept", {8'h0, pf_out}, 16'h00C3);
        chk("R5", "dir reg kept", {8'h0, pc_oe}, 16'h000F);
        chk("R5", "data reg kept", {8'h0, pc_out}, 16'h0035);
    endtask

    task automatic t_bus_cycles();
        step();
        mode_sel = 2'b01; e_clk = 1'b0; step();
        // read cycle with E high
        e_clk = 1'b1; cpu_valid = 1'b1; cpu_rw = 1'b1; cpu_addr = 16'h8000; pc_in = 8'h5A; #1;
        chk("R8", "no drive on read", {8'h0, pc_oe}, 16'h0);
        chk("R7", "rw read", {15'h0, rw_pin}, 16'h1);
        chk("R5", "read data from pad", {8'h0, cpu_rdata}, 16'h005A);
        step();
        e_clk = 1'b0; cpu_valid = 1'b0; step(); step();
        // write cycle with E low first: no drive yet
        cpu_valid = 1'b1; cpu_rw = 1'b0; cpu_wdata = 8'hA5; cpu_addr = 16'h8001; #1;
        chk("R8", "no drive E low", {8'h0, pc_oe}, 16'h0);
        chk("R7", "rw write E low", {15'h0, rw_pin}, 16'h0);
        step();
        e_clk = 1'b1; #1;
        chk("R8", "drive on write", {8'h0, pc_oe}, 16'h00FF);
        chk("R8", "write data", {8'h0, pc_out}, 16'h00A5);
        step();
        // E falls and CPU moves to a read in the same cycle
        e_clk = 1'b0; cpu_rw = 1'b1; cpu_valid = 1'b0; cpu_wdata = 8'h00; cpu_addr = 16'h9000; #1;
        chk("R9", "rw held", {15'h0, rw_pin}, 16'h0);
        chk("R9", "data held", {8'h0, pc_out}, 16'h00A5);
        chk("R9", "drive held", {8'h0, pc_oe}, 16'h00FF);
        chk("R2", "address already new", {pb_out, pf_out}, 16'h9000);
        step(); #1;
        chk("R9", "rw released", {15'h0, rw_pin}, 16'h1);
        chk("R9", "drive released", {8'h0, pc_oe}, 16'h0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_regs();
        t_single_reads();
        t_idle_rw();
        t_bus_addr();
        t_isolation();
        t_bus_cycles();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule